// File: doc/BRIEF.md
# Byte-Wide EPROM Device Model with Mode Decoder

This block models the device side of a byte-wide, ultraviolet-erasable read-only memory, for use inside a larger simulation or emulation fabric. Each cycle it looks at the active-low select, output-gate and write-strobe inputs, and at two flags. One flag says the programming supply is raised. The other says the identification-select address line is at its high-voltage level. From these it picks one of seven operating modes, reports that mode, and either drives the data bus or releases it. The bus is split into a data input, a data output and an output-drive enable.

Storage is a small array whose depth is a parameter. The address stays the full 18 bits, and bits above the array width are ignored. Writing can only turn ones into zeros. A write happens once per low pulse of the strobe, at the first sampled low cycle. A synchronous erase input returns every location to all ones, which stands in for an ultraviolet erase. An identification mode returns a maker byte or a part byte, chosen by address bit 0.

Top module: `eprom_mode_core`

## Requirements
- R1: With select low, output gate low, supply flag low and identification flag low, mode is 2 (read), the drive enable is 1 and the data output equals the byte stored at the address.
- R2: With select high and supply flag low, mode is 0 (standby), the drive enable is 0 and the data output is 0x00, whatever the output gate is doing.
- R3: With select low, output gate high and no program pulse under way, mode is 1 (output disabled) and the drive enable is 0, whether or not the supply flag is raised.
- R4: With supply flag high, select low and strobe low, mode is 3 (program) and the drive enable is 0. This holds even when the output gate is low.
- R5: With supply flag high, select low, output gate low and strobe high, mode is 4 (verify) and the stored byte at the address is driven out.
- R6: With supply flag high and select high, mode is 5 (inhibit), the drive enable is 0, and strobe pulses change no stored byte.
- R7: With supply flag low, select low, output gate low and identification flag high, mode is 6. The output is 0x20 when address bit 0 is 0 and 0x61 when it is 1. Address bit 9 is ignored. If any other address bit is set, the output is 0x00.
- R8: After reset every byte reads 0xFF. A program operation stores the old byte ANDed with the data input, so bits only ever clear.
- R9: Erase high at a clock edge sets every byte to 0xFF from the next cycle. Erase wins over a write in the same cycle.
- R10: Address bits at and above the array index width are ignored in read and verify.
- R11: A write is taken only in the first cycle the strobe is sampled low. Holding the strobe low with new data on later cycles writes nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; array returns to all ones |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Active-low device select |
| oe_n | input | 1 | Active-low output gate |
| pgm_n | input | 1 | Active-low write strobe |
| vpp_hi | input | 1 | Programming supply is at its raised level |
| a9_hi | input | 1 | Identification-select line is at its high-voltage level |
| erase | input | 1 | Synchronous set-all-to-ones |
| din | input | 8 | Byte presented for writing |
| dout | output | 8 | Byte driven when enabled, else 0x00 |
| dout_en | output | 1 | Data bus drive enable |
| mode | output | 3 | Decoded mode code (0 to 6) |

## Verification
The assertions assume the control inputs and the address are steady across each clock cycle and take defined values from reset onward. They also assume the erase input is low whenever reset is asserted. The bit-only-clears property assumes nothing but a program pulse or erase changes stored data. The stimulus changes inputs only on the falling clock edge, one step per cycle. It always returns the strobe high between separate pulses, so every write it intends starts a fresh pulse.

// File: rtl/eprom_mode_core.sv
module eprom_mode_core #(
  parameter int ADDR_W = 18,
  parameter int ARR_AW = 4,
  parameter logic [7:0] MAKER_ID = 8'h20,
  parameter logic [7:0] PART_ID = 8'h61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              a9_hi,
  input  logic              erase,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic [2:0]        mode
);

  localparam int DEPTH = 1 << ARR_AW;
  localparam logic [ADDR_W-1:0] ID_MASK =
    ~((ADDR_W'(1) << 0) | (ADDR_W'(1) << 9));

  localparam logic [2:0] M_STBY = 3'd0;
  localparam logic [2:0] M_OFF  = 3'd1;
  localparam logic [2:0] M_READ = 3'd2;
  localparam logic [2:0] M_PROG = 3'd3;
  localparam logic [2:0] M_VRFY = 3'd4;
  localparam logic [2:0] M_INH  = 3'd5;
  localparam logic [2:0] M_SIG  = 3'd6;

  logic [7:0] cells [DEPTH];
  logic       pgm_q;

  wire [ARR_AW-1:0] idx    = addr[ARR_AW-1:0];
  wire              id_ok  = (addr & ID_MASK) == '0;
  wire [7:0]        id_val = !id_ok ? 8'h00 : (addr[0] ? PART_ID : MAKER_ID);
  wire              strobe = (mode == M_PROG) && pgm_q;

  always_comb begin
    if (ce_n)
      mode = vpp_hi ? M_INH : M_STBY;
    else if (vpp_hi)
      mode = !pgm_n ? M_PROG : (!oe_n ? M_VRFY : M_OFF);
    else if (!oe_n)
      mode = a9_hi ? M_SIG : M_READ;
    else
      mode = M_OFF;
  end

  assign dout_en = (mode == M_READ) || (mode == M_VRFY) || (mode == M_SIG);
  assign dout = (mode == M_SIG) ? id_val :
                dout_en         ? cells[idx] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pgm_q <= 1'b1;
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else begin
      pgm_q <= pgm_n;
      if (erase) begin
        for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
      end else if (strobe) begin
        cells[idx] <= cells[idx] & din;
      end
    end
  end

endmodule

// File: rtl/eprom_mode_chk.sv
module eprom_mode_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              oe_n,
  input logic              pgm_n,
  input logic              vpp_hi,
  input logic              a9_hi,
  input logic              erase,
  input logic [7:0]        dout,
  input logic              dout_en,
  input logic [2:0]        mode
);

  logic [ADDR_W-1:0] other;
  assign other = addr & ~((ADDR_W'(1) << 0) | (ADDR_W'(1) << 9));

  assert_read_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vpp_hi && !a9_hi) |-> (mode == 3'd2 && dout_en));

  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !vpp_hi) |-> (mode == 3'd0 && !dout_en && dout == 8'h00));

  assert_gate_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && pgm_n) |-> (mode == 3'd1 && !dout_en));

  assert_program_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && vpp_hi && !pgm_n) |-> (mode == 3'd3 && !dout_en));

  assert_inhibit_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && vpp_hi) |-> (mode == 3'd5 && !dout_en));

  assert_ident_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vpp_hi && a9_hi && other == '0)
      |-> (dout_en && dout == (addr[0] ? 8'h61 : 8'h20)));

  assert_bits_only_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && $past(mode) == 3'd2 && $stable(addr) && !$past(erase))
      |-> ((dout & ~$past(dout)) == 8'h00));

  assert_erase_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(erase) && mode == 3'd2) |-> (dout == 8'hFF));

endmodule

bind eprom_mode_core eprom_mode_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/eprom_mode_core_tb.sv
`timescale 1ns/1ps
module eprom_mode_core_tb;

  typedef struct {
    logic [2:0] mode;
    logic       en;
    logic [7:0] data;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] addr = '0;
  logic        ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
  logic        vpp_hi = 1'b0, a9_hi = 1'b0, erase = 1'b0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en;
  logic [2:0]  mode;

  int   checks = 0;
  int   fails = 0;
  exp_t q[$];
  event smp;
  logic [7:0] ref_mem [16];
  logic       ref_pq = 1'b1;

  always #10 clk = ~clk;

  eprom_mode_core u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .pgm_n(pgm_n), .vpp_hi(vpp_hi), .a9_hi(a9_hi), .erase(erase),
    .din(din), .dout(dout), .dout_en(dout_en), .mode(mode)
  );

  function automatic logic [2:0] want_mode();
    if (ce_n) return vpp_hi ? 3'd5 : 3'd0;
    if (vpp_hi) return !pgm_n ? 3'd3 : (!oe_n ? 3'd4 : 3'd1);
    if (!oe_n) return a9_hi ? 3'd6 : 3'd2;
    return 3'd1;
  endfunction

  task automatic step(input logic c, o, p, v, a9, input logic [17:0] a,
                      input logic [7:0] d, input logic er, input string tag);
    exp_t e;
    @(negedge clk);
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; a9_hi = a9;
    addr = a; din = d; erase = er;
    #5;
    e.mode = want_mode();
    e.en = (e.mode == 3'd2) || (e.mode == 3'd4) || (e.mode == 3'd6);
    if (e.mode == 3'd6)
      e.data = ((a & ~18'h00201) != 0) ? 8'h00 : (a[0] ? 8'h61 : 8'h20);
    else if (e.en)
      e.data = ref_mem[a[3:0]];
    else
      e.data = 8'h00;
    e.tag = tag;
    q.push_back(e);
    -> smp;
    #1;
    if (er) begin
      for (int i = 0; i < 16; i++) ref_mem[i] = 8'hFF;
    end else if (e.mode == 3'd3 && ref_pq) begin
      ref_mem[a[3:0]] = ref_mem[a[3:0]] & d;
    end
    ref_pq = p;
  endtask

  initial begin
    forever begin
      exp_t e;
      @(smp);
      #0;
      e = q.pop_front();
      checks++;
      if (mode !== e.mode || dout_en !== e.en || dout !== e.data) begin
        fails++;
        $display("FAIL %s: got mode=%0d en=%0b dout=%02h, expected mode=%0d en=%0b dout=%02h",
                 e.tag, mode, dout_en, dout, e.mode, e.en, e.data);
      end
    end
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = 8'hFF;
    repeat (3) @(posedge clk);
    step(1, 1, 1, 0, 0, 18'h0, 8'h00, 0, "R2 reset standby");
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 1, 0, 0, 18'h3, 8'h00, 0, "R8 blank read");
    step(0, 0, 1, 0, 0, 18'hF, 8'h00, 0, "R1 read top byte");
    step(0, 1, 0, 1, 0, 18'h3, 8'hA5, 0, "R4 program pulse");
    step(0, 0, 1, 1, 0, 18'h3, 8'h00, 0, "R5 verify after write");
    step(0, 0, 0, 1, 0, 18'h3, 8'h3C, 0, "R4 program with gate low");
    step(0, 0, 1, 1, 0, 18'h3, 8'hFF, 0, "R8 AND of old and new");
    step(0, 1, 0, 1, 0, 18'h5, 8'h0F, 0, "R11 first low cycle");
    step(0, 1, 0, 1, 0, 18'h5, 8'hF0, 0, "R11 held low");
    step(0, 0, 1, 1, 0, 18'h5, 8'h00, 0, "R11 single write");
    step(1, 1, 0, 1, 0, 18'h7, 8'h00, 0, "R6 inhibit pulse");
    step(1, 0, 1, 1, 0, 18'h7, 8'h00, 0, "R6 inhibit gate low");
    step(0, 0, 1, 1, 0, 18'h7, 8'h00, 0, "R6 no write under inhibit");
    step(0, 1, 1, 0, 0, 18'h3, 8'h00, 0, "R3 gate off normal supply");
    step(0, 1, 1, 1, 0, 18'h3, 8'h00, 0, "R3 gate off raised supply");
    step(0, 0, 1, 0, 0, 18'h10003, 8'h00, 0, "R10 alias high bit");
    step(0, 0, 1, 1, 0, 18'h20015, 8'h00, 0, "R10 alias verify");
    step(0, 0, 1, 0, 1, 18'h0, 8'h00, 0, "R7 maker byte");
    step(0, 0, 1, 0, 1, 18'h1, 8'h00, 0, "R7 part byte");
    step(0, 0, 1, 0, 1, 18'h201, 8'h00, 0, "R7 bit 9 ignored");
    step(0, 0, 1, 0, 1, 18'h4, 8'h00, 0, "R7 stray address bit");
    step(0, 1, 1, 1, 0, 18'h3, 8'h00, 0, "R9 strobe high first");
    step(0, 1, 0, 1, 0, 18'h3, 8'h00, 1, "R9 erase beats write");
    step(0, 0, 1, 0, 0, 18'h3, 8'h00, 0, "R9 erased byte 3");
    step(0, 0, 1, 0, 0, 18'h5, 8'h00, 0, "R9 erased byte 5");
    step(1, 0, 1, 0, 0, 18'h5, 8'h00, 0, "R2 standby gate low");
    step(0, 1, 0, 1, 0, 18'h8, 8'h81, 0, "R4 program after erase");
    step(0, 0, 1, 0, 0, 18'h8, 8'h00, 0, "R1 read written byte");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: got %0d left, expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule